// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block drives a chip-level clock output from its input clock. The output is either the input clock passed straight through or that clock divided by 2, 4, 8 or 16. Software sets it up through an 8-bit mode register. The register is reached over a small write port that carries a per-bit mask, so the same port serves both full-byte writes and single-bit writes. The register holds an output-enable bit and a 3-bit divide selector. The output is held low whenever the enable is clear.

Every divided clock comes from one free-running counter and has a 50% duty cycle. The counter restarts from zero when the output is switched on, so the first edge on the pin is always a clean rising edge. When the output is switched off, the pulse in progress is allowed to finish. The selector is locked while the output runs or is still winding down. Any attempt to load a prohibited selector code is refused and flagged by a one-cycle error pulse.

Top module: `divclk_out`

## Requirements
- R1: After reset the register reads 0x01 (enable clear, selector code 001), `clk_out` is low and `sel_err` is low.
- R2: A byte write (mask 0xFF) loads the enable from bit 4 and the selector from bits 2..0. Bits 7..5 and bit 3 always read 0, even after ones are written to them.
- R3: A masked write changes only the bits whose mask bit is 1. A one-hot mask therefore writes a single bit.
- R4: With selector code 1, 2, 3 or 4 and the enable set, `clk_out` has a period of 2^code input cycles and a high time of exactly half that period.
- R5: With selector code 0 and the enable set, `clk_out` follows the input clock, with a period of one input cycle and a high time of half a cycle.
- R6: While the enable is clear and the output has wound down, `clk_out` stays low in both clock phases.
- R7: After a write sets the enable at clock edge t, the first rising edge of `clk_out` occurs at edge t+1+2^(code-1) for codes 1..4, and at edge t+1 for code 0.
- R8: Clearing the enable never shortens a high phase. Every high pulse on `clk_out`, including the last one, lasts half the selected period.
- R9: A write that would change the selector is ignored while the enable is set or the output is still winding down. The enable bit carried in that same write still takes effect.
- R10: A write whose resulting selector is 5, 6 or 7 leaves the selector unchanged and sets `sel_err` high for exactly the one cycle that follows the write edge.
- R11: A prohibited code written while the output is enabled raises `sel_err`, keeps the running selector and leaves the output period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; all logic is clocked by it |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_mask | input | 8 | Per-bit write mask; only bits set here are written |
| wr_data | input | 8 | Write data for the mode register |
| rd_data | output | 8 | Current mode register contents |
| clk_out | output | 1 | Divided or passed-through clock output |
| sel_err | output | 1 | One-cycle pulse after a prohibited selector code is written |

## Verification
Prohibited-code detection and the selector lock can both act on a single write. That write can also change the enable bit. The bench provokes this by writing code 7 with the enable set while the output runs at divide-by-4. It then checks that the error pulse appears, that the read-back selector is still 2, and that the measured output period stays at four cycles. A second write carries a new legal code and a cleared enable. The bench checks that the enable clears and that the code is dropped.

// File: rtl/divclk_pkg.sv
// Package: divclk_pkg
// Shared constants for the clock output divider: the register width, the
// position of the enable bit and the reset image of the mode register.
// Assumes that the selector field starts at bit 0 and sits below the enable.
package divclk_pkg;
    localparam int REG_W      = 8;
    localparam int EN_POS     = 4;
    localparam int RESET_CODE = 1;
endpackage

// File: rtl/divclk_mode_reg.sv
// Module: divclk_mode_reg
// Holds the enable bit and the divide selector. Applies masked writes,
// refuses prohibited codes, and locks the selector while the output is
// active. Assumes that busy is high for as long as any divided or
// bypassed output path may still be driving the pin.
module divclk_mode_reg
    import divclk_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int MAX_CODE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_mask,
    input  logic [REG_W-1:0] wr_data,
    input  logic             busy,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [REG_W-1:0] rdata_o,
    output logic             err_o
);
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             err_q;
    logic             cand_en;
    logic [SEL_W-1:0] cand_sel;
    logic             code_bad;
    logic             sel_lock;
    logic             reserved_unused;

    // Candidate values after merging the masked write with the held state.
    always_comb begin
        for (int i = 0; i < SEL_W; i++) begin
            cand_sel[i] = wr_mask[i] ? wr_data[i] : sel_q[i];
        end
        cand_en  = wr_mask[EN_POS] ? wr_data[EN_POS] : en_q;
        code_bad = (cand_sel > SEL_W'(MAX_CODE));
        sel_lock = en_q || busy;
    end

    // Reserved write bits carry no state; fold them into a named sink.
    assign reserved_unused = ^{wr_mask, wr_data};

    // Register update: the enable always follows the write; the selector only when legal and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= SEL_W'(RESET_CODE);
            err_q <= 1'b0;
        end else begin
            err_q <= wr_en && code_bad;
            if (wr_en) begin
                en_q <= cand_en;
                if (!code_bad && !sel_lock) begin
                    sel_q <= cand_sel;
                end
            end
        end
    end

    // Read image: the unused bits read as zero.
    always_comb begin
        rdata_o               = '0;
        rdata_o[EN_POS]       = en_q;
        rdata_o[SEL_W-1:0]    = sel_q;
    end

    assign en_o  = en_q;
    assign sel_o = sel_q;
    assign err_o = err_q;

    // The held selector never takes a prohibited code.
    assert_sel_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q <= SEL_W'(MAX_CODE));

    // The selector cannot move while the output is enabled or winding down.
    assert_sel_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q || busy) |=> $stable(sel_q));

    // The write that raised an error left the selector untouched.
    assert_err_keeps_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $stable(sel_q));
endmodule

// File: rtl/divclk_div_core.sv
// Module: divclk_div_core
// Free-running counter with one tap per divide stage. It starts from zero
// when the enable is seen with a divided code selected. Once the enable is
// gone, it stops only when the selected tap is about to fall, so the last
// high phase is never cut short. Assumes that the selector stays still while running.
module divclk_div_core #(
    parameter int DIV_STAGES = 4,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             run_o,
    output logic             div_o
);
    logic [DIV_STAGES-1:0] cnt_q;
    logic [DIV_STAGES-1:0] cnt_inc;
    logic [DIV_STAGES-1:0] tap_hit;
    logic                  run_q;
    logic                  cur_bit;
    logic                  nxt_bit;
    logic                  is_div;

    // One-hot decode of the selector onto counter taps: code k picks bit k-1.
    for (genvar g = 0; g < DIV_STAGES; g++) begin : g_tap
        assign tap_hit[g] = (sel == SEL_W'(g + 1));
    end

    // Tap values now and after the next increment.
    always_comb begin
        cnt_inc = cnt_q + DIV_STAGES'(1);
        cur_bit = |(tap_hit & cnt_q);
        nxt_bit = |(tap_hit & cnt_inc);
        is_div  = |tap_hit;
    end

    // Run control: start from zero, count, and stop at the end of a high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q) begin
            run_q <= en && is_div;
            cnt_q <= '0;
        end else if (!en && !nxt_bit) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    assign run_o = run_q;
    assign div_o = run_q && cur_bit;

    // Each start of the divider begins from a cleared counter.
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (cnt_q == '0));

    // The divider never stops while its output is in a high phase.
    assert_stop_not_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> !$past(cur_bit && nxt_bit));
endmodule

// File: rtl/divclk_out_stage.sv
// Module: divclk_out_stage
// Chooses between the bypassed input clock and the divided clock. The
// bypass gate is updated on the falling edge, so it only opens or closes
// while the input clock is low. Assumes that the divider and the bypass
// are never active together.
module divclk_out_stage #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    input  logic             div_in,
    output logic             byp_o,
    output logic             clk_out
);
    logic byp_q;

    // Bypass gate, moved only while the input clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else begin
            byp_q <= en && (sel == '0);
        end
    end

    // Pin drive: the input clock through the gate, or the divided clock.
    assign clk_out = byp_q ? clk : div_in;
    assign byp_o   = byp_q;

    // Only one output path may be active at a time.
    assert_one_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(byp_q && run));

    // With both paths idle the pin is low even while the clock is high.
    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_q && !run) |-> !clk_out);
endmodule

// File: rtl/divclk_out.sv
// Module: divclk_out
// Top of the programmable clock output divider: the mode register, the
// divider core and the output stage. Assumes that clk is the already
// prescaled source clock and that the pin multiplexing lies outside.
module divclk_out
    import divclk_pkg::*;
#(
    parameter int DIV_STAGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_mask,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_out,
    output logic             sel_err
);
    localparam int SEL_W = $clog2(DIV_STAGES + 1);

    logic             en;
    logic [SEL_W-1:0] sel;
    logic             run;
    logic             div_clk;
    logic             byp;
    logic             busy;

    // The selector stays locked until both output paths have gone quiet.
    assign busy = run || byp;

    divclk_mode_reg #(
        .SEL_W    (SEL_W),
        .MAX_CODE (DIV_STAGES)
    ) mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .busy    (busy),
        .en_o    (en),
        .sel_o   (sel),
        .rdata_o (rd_data),
        .err_o   (sel_err)
    );

    divclk_div_core #(
        .DIV_STAGES (DIV_STAGES),
        .SEL_W      (SEL_W)
    ) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sel   (sel),
        .run_o (run),
        .div_o (div_clk)
    );

    divclk_out_stage #(
        .SEL_W (SEL_W)
    ) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .sel     (sel),
        .run     (run),
        .div_in  (div_clk),
        .byp_o   (byp),
        .clk_out (clk_out)
    );
endmodule

// File: tb/divclk_out_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every legal selector code, measures the output period, the
// high time and the first edge, and probes register writes, locking and
// prohibited codes. Expected values are computed from the requirements.
module divclk_out_tb_top;
    localparam real TCLK = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_mask = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       clk_out;
    logic       sel_err;

    int  n_checks = 0;
    int  n_err = 0;
    real t_wr = 0.0;
    real last_rise = 0.0;
    real prev_rise = 0.0;
    real high_w = 0.0;
    real min_high = 1.0e9;
    real first_rise = 0.0;
    bit  arm = 1'b0;

    always #(TCLK/2.0) clk = ~clk;

    divclk_out dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_out (clk_out),
        .sel_err (sel_err)
    );

    // Edge timing monitor on the output pin.
    always @(posedge clk_out) begin
        prev_rise = last_rise;
        last_rise = $realtime;
        if (arm) begin
            first_rise = $realtime;
            arm = 1'b0;
        end
    end

    always @(negedge clk_out) begin
        high_w = $realtime - last_rise;
        if (high_w < min_high) min_high = high_w;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_t(input string req, input real act, input real exp);
        n_checks++;
        if ((act - exp > 0.01) || (exp - act > 0.01)) begin
            n_err++;
            $display("FAIL %s: actual %0.3f ns expected %0.3f ns", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] m, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mask = m; wr_data = d;
        @(posedge clk);
        t_wr = $realtime;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0; wr_data = '0;
    endtask

    // Enables one code, measures the output, then stops it during a high phase.
    task automatic run_code(input int code);
        real per;
        real exp_first;
        per = TCLK * real'(1 << code);
        write_reg(8'hFF, 8'(code));
        chk($sformatf("R2 select code %0d", code), rd_data, code);
        min_high = 1.0e9;
        arm = 1'b1;
        write_reg(8'hFF, 8'(8'h10 | code));
        exp_first = (code == 0) ? t_wr + TCLK : t_wr + TCLK * real'(1 + (1 << (code - 1)));
        repeat (4 * (1 << code) + 6) @(posedge clk);
        #1;
        chk_t($sformatf("R7 first rise code %0d", code), first_rise, exp_first);
        chk_t($sformatf("R4/R5 period code %0d", code), last_rise - prev_rise, per);
        chk_t($sformatf("R4/R5 high time code %0d", code), high_w, per / 2.0);
        @(posedge clk_out);
        write_reg(8'h10, 8'h00);
        repeat (40) @(posedge clk);
        chk_t($sformatf("R8 shortest pulse code %0d", code), min_high, per / 2.0);
        chk($sformatf("R6 enable clear code %0d", code), rd_data, code);
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            chk("R6 low in high phase", clk_out, 0);
            @(negedge clk); #1;
            chk("R6 low in low phase", clk_out, 0);
        end
    endtask

    initial begin
        #(TCLK * 100000.0);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset image", rd_data, 8'h01);
        chk("R1 reset clk_out", clk_out, 0);
        chk("R1 reset sel_err", sel_err, 0);

        // R2: full byte with reserved bits set.
        write_reg(8'hFF, 8'hEA);
        chk("R2 reserved bits read zero", rd_data, 8'h02);
        write_reg(8'hFF, 8'h01);

        // R3: single-bit writes.
        write_reg(8'h02, 8'h02);
        chk("R3 bit1 write", rd_data, 8'h03);
        write_reg(8'h80, 8'h80);
        chk("R3 reserved bit7 write", rd_data, 8'h03);
        write_reg(8'h04, 8'h04);
        chk("R10 bit write to code 7 flags", sel_err, 1);
        chk("R10 bit write to code 7 keeps code", rd_data, 8'h03);
        @(negedge clk); #1;
        chk("R10 error lasts one cycle", sel_err, 0);

        // R10: prohibited byte write while stopped.
        write_reg(8'hFF, 8'h05);
        chk("R10 code 5 flags", sel_err, 1);
        chk("R10 code 5 keeps code", rd_data, 8'h03);
        write_reg(8'hFF, 8'h06);
        chk("R10 code 6 keeps code", rd_data, 8'h03);

        // R4, R5, R6, R7, R8 over every legal code.
        for (int c = 0; c <= 4; c++) run_code(c);

        // R9 and R11: writes during operation at divide-by-4.
        write_reg(8'hFF, 8'h02);
        write_reg(8'hFF, 8'h12);
        write_reg(8'hFF, 8'h13);
        chk("R9 code change ignored while enabled", rd_data, 8'h12);
        chk("R9 legal locked write no error", sel_err, 0);
        write_reg(8'hFF, 8'h17);
        chk("R11 prohibited while enabled flags", sel_err, 1);
        chk("R11 prohibited while enabled keeps code", rd_data, 8'h12);
        repeat (20) @(posedge clk);
        #1;
        chk_t("R11 period unchanged", last_rise - prev_rise, 4.0 * TCLK);
        write_reg(8'hFF, 8'h03);
        chk("R9 enable clears, code kept", rd_data, 8'h02);
        repeat (40) @(posedge clk);
        write_reg(8'hFF, 8'h03);
        chk("R9 code accepted once stopped", rd_data, 8'h03);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule